// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This unit keeps, for every CPU in a cluster, two inter-processor interrupts: a "remote" kind that any CPU can raise on a set of targets with one write, and a "self" kind that a CPU raises on itself. Each kind has its own pending bit and mask bit. A CPU raises an interrupt line while it has at least one pending, unmasked IPI. It learns which IPI fired by reading the shared event register. That read delivers one IPI, reports it with the IPI type code, and masks it in the same step, so the same IPI is not reported twice.

Every register exists in two forms. A current-CPU view acts on the CPU that makes the access. An explicit view, placed at a fixed stride per CPU, lets any CPU set, clear, mask or unmask the IPIs of a named CPU. The hardware interrupt lines that share the event register live elsewhere. They reach this unit only as a per-CPU busy flag that gives them precedence.

Top module: `ipi_unit`

## Requirements
- R1: After reset both IPIs of every CPU are masked and not pending, `ipi_irq` is all zero, and a mask read returns 0x8000_0001.
- R2: A write to 0x2008 sets the remote IPI pending on each CPU c whose data bit c is 1, for c below NCPU. Bits for CPUs at or above NCPU (below bit 31) have no effect.
- R3: Bit 31 of a 0x2008 write sets the self IPI pending on the writing CPU only.
- R4: A write to 0x200C clears pending on the accessing CPU, with bit 0 for remote and bit 31 for self, one bit per IPI. A read of 0x200C returns the pending bits in those same positions.
- R5: Writing 1s to 0x2024 sets mask bits and writing 1s to 0x2028 clears them (bit 0 remote, bit 31 self) on the accessing CPU. A read of either returns the mask bits in those positions.
- R6: `ipi_irq[c]` is 1 exactly when CPU c has an IPI that is both pending and unmasked.
- R7: A read of 0x2004 returns 0x0004_0001 for a remote IPI and 0x0004_0002 for a self IPI, with remote taking priority, or 0 if neither is pending and unmasked. The value appears on `bus_rdata` one cycle after the read.
- R8: Delivering an IPI through an event read sets its mask bit. The pending bit stays set until it is acknowledged, and the mask stays set until a mask-clear write.
- R9: A pending IPI that is masked is neither reported nor signalled. It is held, and it appears once it is unmasked.
- R10: While `hw_busy` of the reading CPU is 1, an event read returns 0 and changes no state.
- R11: For c below NCPU, the explicit view at base 0x5000+(c<<7) acts on CPU c from any accessor: offset 0x08 sets pending, 0x0C clears pending, 0x24 sets mask, 0x28 clears mask. Reads at these offsets return the same bits as the current view. Accesses that name a CPU at or above NCPU are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cpu | input | 5 | Index of the CPU making the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (event reads are destructive) |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| hw_busy | input | NCPU | Per CPU: a hardware line is awaiting report, so it wins the event read |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| ipi_irq | output | NCPU | Per-CPU interrupt request from pending, unmasked IPIs |

## Verification
The hardest state to reach is a CPU that holds a pending IPI which has already been delivered and auto-masked, while its other IPI is still live. Only that state shows priority, sticky masking and the later release together. The stimulus reaches it by unmasking both IPIs of one CPU and raising both kinds. It then reads the event register twice, once while `hw_busy` blocks delivery and once without. Mask-clear writes before and after acknowledgement then show that a held IPI comes back only while it is still pending.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 16;
  localparam int CPU_ID_W = 5;
  localparam int MAX_CPUS = 31;

  localparam logic [15:0] EVT_KIND_IPI = 16'd4;
  localparam logic [15:0] EVT_NUM_REM  = 16'd1;
  localparam logic [15:0] EVT_NUM_SELF = 16'd2;

  typedef enum logic [2:0] {
    OP_NONE, OP_EVENT, OP_SEND, OP_PSET, OP_PCLR, OP_MSET, OP_MCLR
  } ipi_op_e;

  typedef struct packed {
    ipi_op_e               op;
    logic [CPU_ID_W-1:0]   tgt;
  } ipi_cmd_t;

  // index 0 = remote kind (bus bit 0), index 1 = self kind (bus bit 31)
  function automatic logic [DATA_W-1:0] pair_to_word(input logic [1:0] v);
    return {v[1], {(DATA_W-2){1'b0}}, v[0]};
  endfunction

  function automatic logic [1:0] word_to_pair(input logic [DATA_W-1:0] w);
    return {w[DATA_W-1], w[0]};
  endfunction

  function automatic logic [DATA_W-1:0] event_word(input logic [1:0] live);
    if (live[0])      return {EVT_KIND_IPI, EVT_NUM_REM};
    else if (live[1]) return {EVT_KIND_IPI, EVT_NUM_SELF};
    else              return '0;
  endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CPU_ID_W-1:0] cur_cpu,
  output ipi_cmd_t            cmd
);
  localparam logic [3:0] PAGE_CUR = 4'h2;
  localparam logic [3:0] PAGE_PER = 4'h5;

  logic [CPU_ID_W-1:0] per_cpu;
  assign per_cpu = addr[11:7];

  always_comb begin
    cmd.op  = OP_NONE;
    cmd.tgt = cur_cpu;
    if (addr[15:12] == PAGE_CUR && int'(cur_cpu) < NCPU) begin
      unique case (addr[11:0])
        12'h004: cmd.op = OP_EVENT;
        12'h008: cmd.op = OP_SEND;
        12'h00C: cmd.op = OP_PCLR;
        12'h024: cmd.op = OP_MSET;
        12'h028: cmd.op = OP_MCLR;
        default: cmd.op = OP_NONE;
      endcase
    end else if (addr[15:12] == PAGE_PER && int'(per_cpu) < NCPU) begin
      cmd.tgt = per_cpu;
      unique case (addr[6:0])
        7'h08:   cmd.op = OP_PSET;
        7'h0C:   cmd.op = OP_PCLR;
        7'h24:   cmd.op = OP_MSET;
        7'h28:   cmd.op = OP_MCLR;
        default: cmd.op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_req,
  input  logic [1:0] clr_req,
  input  logic [1:0] mset_req,
  input  logic [1:0] mclr_req,
  input  logic       take,
  output logic [1:0] pend,
  output logic [1:0] mask,
  output logic [1:0] live,
  output logic [1:0] taken,
  output logic       irq
);
  logic [1:0] pend_q, mask_q;

  assign live     = pend_q & ~mask_q;
  assign taken[0] = take & live[0];
  assign taken[1] = take & ~live[0] & live[1];
  assign irq      = |live;
  assign pend     = pend_q;
  assign mask     = mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 2'b00;
      mask_q <= 2'b11;
    end else begin
      pend_q <= (pend_q | set_req) & ~clr_req;
      mask_q <= (mask_q | mset_req | taken) & ~mclr_req;
    end
  end

  AST_AUTO_MASK_REM: assert property (@(posedge clk) disable iff (!rst_n)
    taken[0] |=> mask_q[0]); // R8
  AST_AUTO_MASK_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    taken[1] |=> mask_q[1]); // R8
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && !clr_req[0]) |=> pend_q[0]); // R8
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[1] && !mclr_req[1]) |=> mask_q[1]); // R9
  AST_ONE_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taken)); // R7
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_ID_W-1:0] bus_cpu,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [NCPU-1:0]     hw_busy,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NCPU-1:0]     ipi_irq
);
  ipi_cmd_t cmd;

  ipi_decode #(.NCPU(NCPU)) u_decode (
    .addr    (bus_addr),
    .cur_cpu (bus_cpu),
    .cmd     (cmd)
  );

  logic [1:0] wr_pair;
  assign wr_pair = word_to_pair(bus_wdata);

  logic [1:0] pend_a  [NCPU];
  logic [1:0] mask_a  [NCPU];
  logic [1:0] live_a  [NCPU];
  logic [1:0] taken_a [NCPU];
  logic [NCPU-1:0] hit;
  logic [NCPU-1:0] take_v;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [1:0] set_req, clr_req, mset_req, mclr_req;

    assign hit[c] = (int'(cmd.tgt) == c) && (cmd.op != OP_NONE);

    // R2: remote IPI per target bit; R3: self bit lands on the sender; R11: explicit set
    assign set_req[0] = bus_wr && ((cmd.op == OP_SEND && bus_wdata[c]) ||
                                   (cmd.op == OP_PSET && hit[c] && wr_pair[0]));
    assign set_req[1] = bus_wr && hit[c] && wr_pair[1] &&
                        (cmd.op == OP_SEND || cmd.op == OP_PSET);
    assign clr_req  = (bus_wr && hit[c] && cmd.op == OP_PCLR) ? wr_pair : 2'b00; // R4
    assign mset_req = (bus_wr && hit[c] && cmd.op == OP_MSET) ? wr_pair : 2'b00; // R5
    assign mclr_req = (bus_wr && hit[c] && cmd.op == OP_MCLR) ? wr_pair : 2'b00; // R5
    assign take_v[c] = bus_rd && hit[c] && cmd.op == OP_EVENT && !hw_busy[c];    // R10

    ipi_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (set_req),
      .clr_req  (clr_req),
      .mset_req (mset_req),
      .mclr_req (mclr_req),
      .take     (take_v[c]),
      .pend     (pend_a[c]),
      .mask     (mask_a[c]),
      .live     (live_a[c]),
      .taken    (taken_a[c]),
      .irq      (ipi_irq[c])
    );
  end

  logic [DATA_W-1:0] rd_value;
  logic              hw_hit;

  always_comb begin
    rd_value = '0;
    hw_hit   = 1'b0;
    for (int c = 0; c < NCPU; c++) begin
      if (hit[c]) begin
        hw_hit = hw_busy[c];
        unique case (cmd.op)
          OP_EVENT:        rd_value = hw_busy[c] ? '0 : event_word(live_a[c]); // R7
          OP_PSET, OP_PCLR: rd_value = pair_to_word(pend_a[c]);
          OP_MSET, OP_MCLR: rd_value = pair_to_word(mask_a[c]);
          default:          rd_value = '0;
        endcase
      end
    end
  end

  logic evt_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      evt_rd_q  <= 1'b0;
    end else begin
      evt_rd_q <= bus_rd && cmd.op == OP_EVENT;
      if (bus_rd) bus_rdata <= rd_value;
    end
  end

  AST_HW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && cmd.op == OP_EVENT && hw_hit) |=> bus_rdata == '0); // R10
  AST_EVT_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd_q && bus_rdata != '0) |-> (bus_rdata[31:16] == EVT_KIND_IPI &&
     (bus_rdata[15:0] == EVT_NUM_REM || bus_rdata[15:0] == EVT_NUM_SELF))); // R7
  AST_QUIET_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_v == '0 && !bus_wr) |=> $stable(ipi_irq)); // R6
endmodule

// File: tb/test_ipi_unit.sv
`timescale 1ns/1ps
module test_ipi_unit;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_cpu = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [NCPU-1:0] hw_busy = '0;
  logic [31:0] bus_rdata;
  logic [NCPU-1:0] ipi_irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  ipi_unit #(.NCPU(NCPU)) i_ipi_unit (
    .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .hw_busy(hw_busy),
    .bus_rdata(bus_rdata), .ipi_irq(ipi_irq)
  );

  function automatic logic [15:0] per_addr(input int c, input logic [6:0] off);
    return 16'h5000 + 16'(c << 7) + 16'(off);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cpu = 5'(cpu); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issue a read and push the expected value for the monitor
  task automatic rd(input int cpu, input logic [15:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_cpu = 5'(cpu); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [NCPU-1:0] e, input string tag);
    @(negedge clk);
    check(32'(ipi_irq), 32'(e), tag);
  endtask

  // monitor: compare registered read data one cycle after each read
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard unexpected read actual=%h expected=none", bus_rdata);
        end else begin
          check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq('0, "R1 irq after reset");
    rd(0, 16'h2024, 32'h8000_0001, "R1 mask reset");
    rd(2, 16'h200C, 32'h0, "R1 pend reset");

    // R2 remote send to cpus 1,2; bit 5 is beyond NCPU and ignored
    wr(0, 16'h2008, 32'h0000_0026);
    rd(0, per_addr(1, 7'h0C), 32'h1, "R2 R11 cpu1 remote pending");
    rd(2, 16'h200C, 32'h1, "R2 cpu2 remote pending");
    rd(0, 16'h200C, 32'h0, "R2 sender not targeted");
    chk_irq('0, "R9 masked pending gives no irq");
    rd(1, 16'h2004, 32'h0, "R9 masked not reported");

    // R5 unmask both on cpu1
    wr(1, 16'h2028, 32'h8000_0001);
    rd(1, 16'h2024, 32'h0, "R5 mask cleared");
    chk_irq(4'b0010, "R6 irq cpu1");

    // R3 self send
    wr(1, 16'h2008, 32'h8000_0000);
    rd(1, 16'h200C, 32'h8000_0001, "R3 self pending on sender");
    rd(0, 16'h200C, 32'h0, "R3 no self on others");

    // R10 hardware line wins
    hw_busy = 4'b0010;
    rd(1, 16'h2004, 32'h0, "R10 event blocked");
    hw_busy = '0;
    rd(1, 16'h2024, 32'h0, "R10 mask untouched");

    // R7 R8 delivery order and auto mask
    rd(1, 16'h2004, 32'h0004_0001, "R7 remote first");
    rd(1, 16'h2024, 32'h0000_0001, "R8 remote auto masked");
    rd(1, 16'h200C, 32'h8000_0001, "R8 pending held");
    chk_irq(4'b0010, "R6 self still live");
    rd(1, 16'h2004, 32'h0004_0002, "R7 self next");
    chk_irq('0, "R8 R6 all masked");
    rd(1, 16'h2004, 32'h0, "R7 nothing left");

    // R4 ack then unmask remote: nothing returns
    wr(1, 16'h200C, 32'h0000_0001);
    rd(1, 16'h200C, 32'h8000_0000, "R4 remote acked");
    wr(1, 16'h2028, 32'h0000_0001);
    chk_irq('0, "R6 acked stays quiet");
    rd(1, 16'h2024, 32'h8000_0000, "R5 mask view");
    // R9 held self returns on unmask
    wr(1, 16'h2028, 32'h8000_0000);
    chk_irq(4'b0010, "R9 held self reappears");
    rd(1, 16'h2004, 32'h0004_0002, "R9 held self reported");
    wr(1, 16'h200C, 32'h8000_0000);
    rd(1, 16'h200C, 32'h0, "R4 self acked");

    // R11 explicit per-cpu view on cpu3 from cpu0
    wr(0, per_addr(3, 7'h08), 32'h8000_0000);
    wr(0, per_addr(3, 7'h28), 32'h8000_0000);
    chk_irq(4'b1000, "R11 cpu3 self via view");
    rd(3, 16'h2004, 32'h0004_0002, "R11 cpu3 event");
    rd(0, per_addr(3, 7'h24), 32'h8000_0001, "R11 R8 cpu3 mask view");
    wr(0, per_addr(3, 7'h0C), 32'h8000_0000);
    rd(0, per_addr(3, 7'h0C), 32'h0, "R11 cpu3 cleared");
    // out of range cpu ignored
    wr(0, per_addr(5, 7'h08), 32'h8000_0001);
    wr(0, per_addr(5, 7'h28), 32'h8000_0001);
    chk_irq('0, "R11 out of range ignored");
    rd(0, 16'h2024, 32'h8000_0001, "R11 cpu0 mask untouched");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule